// File: doc/BRIEF.md
# Masked Slide-by-One Vector Merge Unit

This block performs a single-element slide of a vector register group, either towards higher indices (up) or towards lower indices (down), and merges the result with a second source vector under a mask. The slide source `vs2` supplies the shifted values. The merge source `vs1` supplies every element that the mask leaves inactive and every element past the active vector length. The element that the slide vacates is filled with binary zero when its mask bit is set.

The result is the same as copying `vs1` into the destination and then running a masked slide with a zero scalar over it, but it is produced in one operation. A caller presents both vectors, the mask, the active length `vl` and a direction. It pulses `start` for one cycle. The registered destination vector and a one-cycle `done` pulse appear on the next clock. Passing the same vector as both sources with an alternating mask duplicates neighbouring elements into each other's slots, which is useful for even/odd interleaving.

Element k occupies bits `[k*SEW +: SEW]` of each vector port, and mask bit k belongs to element k. The element count `VLMAX` and the element width `SEW` are parameters.

Top module: `vec_slide1_merge`

## Requirements
- R1: An element at index i < vl whose mask bit is 0 takes `vs1` element i.
- R2: Every element at index i >= vl takes `vs1` element i, whatever its mask bit.
- R3: With `dir_i`=0 (up), an element at index i, 0 < i < vl, whose mask bit is 1 takes `vs2` element i-1.
- R4: With `dir_i`=0 (up), vl > 0 and mask bit 0 set, result element 0 is all zeros.
- R5: With `dir_i`=1 (down), an element at index i < vl-1 whose mask bit is 1 takes `vs2` element i+1.
- R6: With `dir_i`=1 (down), vl > 0 and mask bit vl-1 set, result element vl-1 is all zeros, even when `vs2` element vl is non-zero.
- R7: When `vl_i` is 0 the whole result equals `vs1`. A `vl_i` above VLMAX is treated as VLMAX.
- R8: `vd_o` is loaded on the clock edge where `start_i` is high. `done_o` is high in exactly the cycle after each `start_i` cycle and low otherwise. Reset clears `vd_o` to 0 and `done_o` to 0.
- R9: `vd_o` keeps its value in every cycle that follows a cycle without `start_i`.
- R10: With `vs1` equal to `vs2` and vl = VLMAX, the up direction with mask bits set only at odd indices copies each even element into the next odd slot. The down direction with mask bits set only at even indices copies each odd element into the preceding even slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle operation strobe |
| dir_i | input | 1 | 0 = slide up, 1 = slide down |
| vl_i | input | VL_W | Active vector length; saturates at VLMAX |
| mask_i | input | VLMAX | Per-element mask, bit k for element k |
| vs2_i | input | VLMAX*SEW | Slide source vector |
| vs1_i | input | VLMAX*SEW | Merge source vector |
| vd_o | output | VLMAX*SEW | Registered destination vector |
| done_o | output | 1 | Pulses high the cycle after start |

## Verification
The hardest case to bring about is the zero fill at the down-direction end, element vl-1, when vl is below VLMAX. There the lane must ignore `vs2` element vl even though that element holds a real value. The stimulus therefore pairs short lengths with a fully set mask and an all-non-zero `vs2`, so a lane that slides in from beyond vl shows up as a non-zero value. Saturation is reached by driving lengths above VLMAX. Random operations are interleaved with idle gaps so that the hold behaviour is observed between loads.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } slide_dir_e;
endpackage

// File: rtl/vsm_vl_sat.sv
module vsm_vl_sat #(
  parameter int VLMAX = 8,
  parameter int VL_W  = 5,
  parameter int CW    = 4
) (
  input  logic [VL_W-1:0] vl_raw,
  output logic [CW-1:0]   vl_eff
);
  localparam logic [VL_W-1:0] LIMIT = VL_W'(VLMAX);

  always_comb begin
    if (vl_raw > LIMIT) vl_eff = CW'(VLMAX);
    else                vl_eff = vl_raw[CW-1:0];
  end
endmodule

// File: rtl/vsm_lane.sv
module vsm_lane
  import vsm_pkg::*;
#(
  parameter int SEW = 8,
  parameter int IDX = 0,
  parameter int CW  = 4
) (
  input  slide_dir_e     dir,
  input  logic [CW-1:0]  vl_eff,
  input  logic           mask_bit,
  input  logic [SEW-1:0] merge_val,
  input  logic [SEW-1:0] from_below,
  input  logic [SEW-1:0] from_above,
  output logic [SEW-1:0] res
);
  localparam logic [CW-1:0] IDX_C = CW'(IDX);
  localparam logic [CW-1:0] NXT_C = CW'(IDX + 1);

  logic in_body;
  logic is_last;

  assign in_body = IDX_C < vl_eff;
  assign is_last = (vl_eff == NXT_C);

  always_comb begin
    if (!in_body || !mask_bit) begin
      res = merge_val;
    end else if (dir == DIR_UP) begin
      res = from_below;
    end else if (is_last) begin
      res = '0;
    end else begin
      res = from_above;
    end
  end
endmodule

// File: rtl/vsm_out_reg.sv
module vsm_out_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      done <= 1'b0;
    end else begin
      done <= load;
      if (load) q <= d;
    end
  end

  a_r8_done_after_start: assert property (@(posedge clk) disable iff (rst)
    load |=> done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    !load |=> !done);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/vec_slide1_merge.sv
module vec_slide1_merge
  import vsm_pkg::*;
#(
  parameter int VLMAX = 8,
  parameter int SEW   = 8,
  parameter int VL_W  = $clog2(VLMAX) + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 dir_i,
  input  logic [VL_W-1:0]      vl_i,
  input  logic [VLMAX-1:0]     mask_i,
  input  logic [VLMAX*SEW-1:0] vs2_i,
  input  logic [VLMAX*SEW-1:0] vs1_i,
  output logic [VLMAX*SEW-1:0] vd_o,
  output logic                 done_o
);
  localparam int CW = $clog2(VLMAX + 1);
  localparam int VW = VLMAX * SEW;
  localparam logic [VL_W-1:0] VLMAX_V = VL_W'(VLMAX);

  logic [CW-1:0] vl_eff;
  logic [VW-1:0] next_vd;
  slide_dir_e    dir;

  assign dir = slide_dir_e'(dir_i);

  vsm_vl_sat #(.VLMAX(VLMAX), .VL_W(VL_W), .CW(CW)) u_sat (
    .vl_raw (vl_i),
    .vl_eff (vl_eff)
  );

  for (genvar g = 0; g < VLMAX; g++) begin : g_lane
    logic [SEW-1:0] below;
    logic [SEW-1:0] above;
    if (g == 0) begin : g_lo_edge
      assign below = '0;
    end else begin : g_lo_mid
      assign below = vs2_i[(g-1)*SEW +: SEW];
    end
    if (g == VLMAX - 1) begin : g_hi_edge
      assign above = '0;
    end else begin : g_hi_mid
      assign above = vs2_i[(g+1)*SEW +: SEW];
    end
    vsm_lane #(.SEW(SEW), .IDX(g), .CW(CW)) u_lane (
      .dir        (dir),
      .vl_eff     (vl_eff),
      .mask_bit   (mask_i[g]),
      .merge_val  (vs1_i[g*SEW +: SEW]),
      .from_below (below),
      .from_above (above),
      .res        (next_vd[g*SEW +: SEW])
    );
  end

  vsm_out_reg #(.W(VW)) u_oreg (
    .clk  (clk),
    .rst  (rst),
    .load (start_i),
    .d    (next_vd),
    .q    (vd_o),
    .done (done_o)
  );

  a_r7_zero_len_copy: assert property (@(posedge clk) disable iff (rst)
    (start_i && vl_i == '0) |=> (vd_o == $past(vs1_i)));
  a_r4_up_head_zero: assert property (@(posedge clk) disable iff (rst)
    (start_i && !dir_i && mask_i[0] && vl_i != '0) |=> (vd_o[SEW-1:0] == '0));
  a_r2_top_tail: assert property (@(posedge clk) disable iff (rst)
    (start_i && vl_i < VLMAX_V) |=>
      (vd_o[VW-1 -: SEW] == $past(vs1_i[VW-1 -: SEW])));
endmodule

// File: tb/vec_slide1_merge_tb.sv
`timescale 1ns/1ps
module vec_slide1_merge_tb;
  localparam int VLMAX = 8;
  localparam int SEW   = 8;
  localparam int VL_W  = $clog2(VLMAX) + 2;
  localparam int VW    = VLMAX * SEW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic dir_i = 1'b0;
  logic [VL_W-1:0] vl_i = '0;
  logic [VLMAX-1:0] mask_i = '0;
  logic [VW-1:0] vs2_i = '0;
  logic [VW-1:0] vs1_i = '0;
  logic [VW-1:0] vd_o;
  logic done_o;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  string cur_tag = "R1";

  logic [VW-1:0] mdl_vd;
  logic mdl_done;

  always #2 clk = ~clk;

  vec_slide1_merge #(.VLMAX(VLMAX), .SEW(SEW), .VL_W(VL_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i), .vl_i(vl_i),
    .mask_i(mask_i), .vs2_i(vs2_i), .vs1_i(vs1_i), .vd_o(vd_o), .done_o(done_o)
  );

  function automatic logic [VW-1:0] ref_op(input bit dn, input int vl_in,
      input logic [VLMAX-1:0] m, input logic [VW-1:0] s2, input logic [VW-1:0] s1);
    logic [VW-1:0] r;
    int n;
    n = (vl_in > VLMAX) ? VLMAX : vl_in;
    r = s1;
    for (int i = 0; i < n; i++) begin
      if (m[i]) begin
        if (!dn) r[i*SEW +: SEW] = (i == 0) ? '0 : s2[(i-1)*SEW +: SEW];
        else     r[i*SEW +: SEW] = (i == n-1) ? '0 : s2[(i+1)*SEW +: SEW];
      end
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mdl_vd <= '0;
      mdl_done <= 1'b0;
    end else begin
      mdl_done <= start_i;
      if (start_i) mdl_vd <= ref_op(dir_i, int'(vl_i), mask_i, vs2_i, vs1_i);
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      n_tests++;
      if (vd_o !== mdl_vd) begin
        n_fail++;
        $display("FAIL %s model vd: actual %h expected %h", cur_tag, vd_o, mdl_vd);
      end
      n_tests++;
      if (done_o !== mdl_done) begin
        n_fail++;
        $display("FAIL R8 model done: actual %b expected %b", done_o, mdl_done);
      end
    end
  end

  task automatic check_vec(input string tag, input logic [VW-1:0] exp);
    n_tests++;
    if (vd_o !== exp) begin
      n_fail++;
      $display("FAIL %s vd: actual %h expected %h", tag, vd_o, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s bit: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input bit dn, input int vl,
      input logic [VLMAX-1:0] m, input logic [VW-1:0] s2, input logic [VW-1:0] s1);
    @(negedge clk);
    cur_tag = tag;
    start_i = 1'b1; dir_i = dn; vl_i = VL_W'(vl);
    mask_i = m; vs2_i = s2; vs1_i = s1;
    @(negedge clk);
    start_i = 1'b0;
    check_bit({tag, " done"}, done_o, 1'b1);
  endtask

  logic [VW-1:0] a_vec, b_vec, exp;

  initial begin
    for (int i = 0; i < VLMAX; i++) begin
      a_vec[i*SEW +: SEW] = SEW'(8'h10 + i);
      b_vec[i*SEW +: SEW] = SEW'(8'hA0 + i);
    end
    repeat (3) @(negedge clk);
    check_vec("R8 reset", '0);
    check_bit("R8 reset done", done_o, 1'b0);
    rst = 1'b0;

    // R3: full mask, up
    run("R3", 0, 8, 8'hFF, a_vec, b_vec);
    exp = {a_vec[VW-SEW-1:0], {SEW{1'b0}}};
    check_vec("R3", exp);
    @(negedge clk);
    check_bit("R8 single pulse", done_o, 1'b0);

    // R5/R6: full mask, down, vl=VLMAX
    run("R5", 1, 8, 8'hFF, a_vec, b_vec);
    exp = {{SEW{1'b0}}, a_vec[VW-1:SEW]};
    check_vec("R5", exp);

    // R6: down with vl=5, vs2[5] non-zero must not leak
    run("R6", 1, 5, 8'hFF, a_vec, b_vec);
    exp = b_vec;
    for (int i = 0; i < 4; i++) exp[i*SEW +: SEW] = a_vec[(i+1)*SEW +: SEW];
    exp[4*SEW +: SEW] = '0;
    check_vec("R6", exp);

    // R4 and R2: up vl=3 mask all ones, tail from vs1
    run("R4", 0, 3, 8'hFF, a_vec, b_vec);
    exp = b_vec;
    exp[0 +: SEW] = '0;
    exp[SEW +: SEW] = a_vec[0 +: SEW];
    exp[2*SEW +: SEW] = a_vec[SEW +: SEW];
    check_vec("R4 R2", exp);

    // R1: mask clear in body
    run("R1", 0, 8, 8'h00, a_vec, b_vec);
    check_vec("R1", b_vec);

    // R7: vl=0 copies vs1
    run("R7", 1, 0, 8'hFF, a_vec, b_vec);
    check_vec("R7 zero", b_vec);

    // R7: saturation, vl=13 behaves as 8
    run("R7", 1, 13, 8'hFF, a_vec, b_vec);
    check_vec("R7 sat", {{SEW{1'b0}}, a_vec[VW-1:SEW]});

    // R10: duplicate even into odd, up, mask odd bits
    run("R10", 0, 8, 8'hAA, a_vec, a_vec);
    for (int i = 0; i < VLMAX; i++)
      exp[i*SEW +: SEW] = a_vec[((i % 2 == 1) ? i-1 : i)*SEW +: SEW];
    check_vec("R10 up", exp);

    // R10: duplicate odd into even, down, mask even bits
    run("R10", 1, 8, 8'h55, a_vec, a_vec);
    for (int i = 0; i < VLMAX; i++)
      exp[i*SEW +: SEW] = a_vec[((i % 2 == 0) ? i+1 : i)*SEW +: SEW];
    check_vec("R10 down", exp);

    // R9: hold across idle cycles
    cur_tag = "R9";
    vs1_i = '1; vs2_i = '1; mask_i = '1;
    repeat (4) @(negedge clk);
    check_vec("R9 hold", exp);

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic [VW-1:0] r1, r2;
      r1 = {$urandom, $urandom};
      r2 = {$urandom, $urandom};
      run("R1 R2 R3 R5 random", $urandom_range(0, 1), $urandom_range(0, 12),
          VLMAX'($urandom), r2, r1);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule